// File: doc/BRIEF.md
# Streaming Separable Gaussian Blur

This block smooths a raster-scanned image stream with a 3x3 Gaussian kernel split into a horizontal pass and a vertical pass. Pixels arrive one per accepted handshake, row after row. The block holds only a three-entry horizontal pixel window and a line store of three rows of horizontal sums, so it never needs a full frame. Both passes run inside one raster scan. The vertical pass trails the horizontal one by one row and one column. Each frame therefore takes (IMG_W+1)x(IMG_H+1) scan steps, and the steps beyond the frame edge take no input.

Every output position on the outermost ring of the frame is sent as zero. Each interior position receives the weighted sum of its 3x3 neighbourhood, shifted right by log2 of the total kernel weight. With the default weights (centre 2, side 1) the total is 16. Both ports use a valid/ready handshake. A full output register stalls the scan without losing or repeating any pixel.

The scan is driven by a three-state controller:
- S_IDLE waits for a start-of-frame pixel and moves to S_FILL when it arrives.
- S_FILL consumes one input pixel per step. It moves to S_DRAIN when the next scan step lies beyond the right or the bottom edge. It returns to S_IDLE when an end-of-line marker arrives at the wrong column.
- S_DRAIN produces steps without input. It moves back to S_FILL at the start of the next real row, and to S_IDLE after the final step (column IMG_W, row IMG_H).

A start-of-frame pixel accepted in S_FILL restarts the scan at row 0, column 0.

Top module: `gblur_stream`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Each frame produces IMG_W x IMG_H output pixels in raster order. out_sof is 1 only on position (0,0), and out_eol is 1 only on the last column (IMG_W-1) of each row.
- R3: An interior output at column c and row r equals floor(sum of w(dx)*w(dy)*p(c+dx, r+dy) / 16) for dx and dy in {-1,0,+1}, where w(0)=2 and w(+-1)=1 (default weights).
- R4: An output whose column is 0 or IMG_W-1, or whose row is 0 or IMG_H-1, is 0.
- R5: With no stalls, the first output of a frame becomes visible in the cycle after the (IMG_W+2)-th input pixel of that frame is accepted.
- R6: During flush steps (scan column IMG_W, or scan row IMG_H) in_ready is 0. With no stalls and input always offered, in_ready is low for exactly IMG_H-1 cycles between the frame's first and last accepted pixels.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_pix holds its value.
- R8: A start-of-frame pixel accepted mid-frame abandons the current frame and starts a new one. The new frame's outputs match R2 to R4.
- R9: A pixel accepted with in_eol=1 at a column other than IMG_W-1 abandons the frame. Until the next start-of-frame pixel, input is accepted and discarded and no output is produced.
- R10: A frame of all-255 pixels yields 255 at every interior position, so the accumulators do not overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel offered |
| in_ready | output | 1 | Block accepts the offered pixel |
| in_pix | input | PIX_W | Input pixel value |
| in_sof | input | 1 | Pixel is position (0,0) of a new frame |
| in_eol | input | 1 | Pixel is the last one of its row |
| out_valid | output | 1 | Output pixel available |
| out_ready | input | 1 | Downstream takes the output pixel |
| out_pix | output | PIX_W | Blurred pixel value |
| out_sof | output | 1 | Output is position (0,0) |
| out_eol | output | 1 | Output is the last one of its row |

## Verification
The hardest case to reach is a full output register that blocks a flush step, while the line store still holds horizontal sums waiting for their vertical partner. Input cannot reach the block during those steps, so the case only arises when backpressure lines up with the drain column. The stimulus reaches it by driving out_ready in a period-three pattern against input gaps of period two, and then checks every output value and that outputs held under stall do not change. A mid-frame restart and a misplaced end-of-line marker are driven from partially sent frames, each followed by a clean frame.

// File: rtl/gblur_pkg.sv
package gblur_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FILL  = 2'd1,
        S_DRAIN = 2'd2
    } scan_state_t;

    // advance a modulo-3 index
    function automatic logic [1:0] m3_inc(input logic [1:0] v);
        return (v == 2'd2) ? 2'd0 : v + 2'd1;
    endfunction

    // step a modulo-3 index back
    function automatic logic [1:0] m3_dec(input logic [1:0] v);
        return (v == 2'd0) ? 2'd2 : v - 2'd1;
    endfunction

    // bits needed to hold a full-scale pixel times a gain
    function automatic int sum_bits(input int pix_bits, input int gain);
        return $clog2(((1 << pix_bits) - 1) * gain + 1);
    endfunction

endpackage

// File: rtl/gblur_scan_ctrl.sv
module gblur_scan_ctrl
    import gblur_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 12,
    localparam int XW = $clog2(IMG_W + 1),
    localparam int YW = $clog2(IMG_H + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eol,
    input  logic          out_space,
    output logic          in_ready,
    output logic          step_go,
    output logic          step_take,
    output logic [XW-1:0] step_x,
    output logic [YW-1:0] step_y,
    output logic [1:0]    step_cm3,
    output logic [1:0]    step_rm3
);

    localparam logic [XW-1:0] X_LAST = XW'(IMG_W - 1);
    localparam logic [XW-1:0] X_END  = XW'(IMG_W);
    localparam logic [YW-1:0] Y_END  = YW'(IMG_H);

    scan_state_t   st_q, st_d;
    logic [XW-1:0] x_q, x_d, x_n;
    logic [YW-1:0] y_q, y_d, y_n;
    logic [1:0]    cm_q, cm_d, cm_n;
    logic [1:0]    rm_q, rm_d, rm_n;
    logic          acc, restart, framed, bad_eol, last_step;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
            x_q  <= '0;
            y_q  <= '0;
            cm_q <= 2'd0;
            rm_q <= 2'd0;
        end else begin
            st_q <= st_d;
            x_q  <= x_d;
            y_q  <= y_d;
            cm_q <= cm_d;
            rm_q <= rm_d;
        end
    end

    // outputs: handshake and effective scan position
    always_comb begin
        in_ready  = (st_q != S_DRAIN) && out_space;
        acc       = in_valid && in_ready;
        restart   = acc && in_sof;
        step_x    = restart ? '0 : x_q;
        step_y    = restart ? '0 : y_q;
        step_cm3  = restart ? 2'd0 : cm_q;
        step_rm3  = restart ? 2'd0 : rm_q;
        framed    = (st_q == S_FILL) || in_sof;
        bad_eol   = acc && framed && in_eol && (step_x != X_LAST);
        step_take = acc && framed && !bad_eol;
        step_go   = (st_q == S_DRAIN) ? out_space : step_take;
    end

    // next scan position
    always_comb begin
        last_step = (step_x == X_END) && (step_y == Y_END);
        if (last_step) begin
            x_n  = '0;
            y_n  = '0;
            cm_n = 2'd0;
            rm_n = 2'd0;
        end else if (step_x == X_END) begin
            x_n  = '0;
            y_n  = step_y + 1'b1;
            cm_n = 2'd0;
            rm_n = m3_inc(step_rm3);
        end else begin
            x_n  = step_x + 1'b1;
            y_n  = step_y;
            cm_n = m3_inc(step_cm3);
            rm_n = step_rm3;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        x_d  = x_q;
        y_d  = y_q;
        cm_d = cm_q;
        rm_d = rm_q;
        if (step_go) begin
            x_d  = x_n;
            y_d  = y_n;
            cm_d = cm_n;
            rm_d = rm_n;
        end
        unique case (st_q)
            S_IDLE: begin
                if (step_go) st_d = S_FILL;
            end
            S_FILL: begin
                if (bad_eol)
                    st_d = S_IDLE;
                else if (step_go)
                    st_d = ((x_n == X_END) || (y_n == Y_END)) ? S_DRAIN : S_FILL;
            end
            S_DRAIN: begin
                if (step_go) begin
                    if (last_step)
                        st_d = S_IDLE;
                    else if ((x_n != X_END) && (y_n != Y_END))
                        st_d = S_FILL;
                    else
                        st_d = S_DRAIN;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    AST_DRAIN_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_DRAIN) |-> !in_ready); // R6
    AST_COL_MOD3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cm_q) == 32'(x_q) % 3)); // R2
    AST_ROW_MOD3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rm_q) == 32'(y_q) % 3)); // R2
    AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (step_take && in_sof) |=> (x_q == XW'(1) && y_q == '0 && st_q == S_FILL)); // R8
    AST_EOL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        bad_eol |=> (st_q == S_IDLE)); // R9

endmodule

// File: rtl/gblur_hpass.sv
module gblur_hpass
    import gblur_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int W_CTR  = 2,
    parameter int W_SIDE = 1,
    localparam int T1D = W_CTR + 2 * W_SIDE,
    localparam int H_W = sum_bits(PIX_W, T1D)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [1:0]       cm3,
    input  logic [PIX_W-1:0] pix_in,
    output logic [H_W-1:0]   hout
);

    logic [PIX_W-1:0] win [3];
    logic [PIX_W-1:0] p_far, p_mid;

    // circular window indexed by column modulo 3
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) win[i] <= '0;
        end else if (load) begin
            win[cm3] <= pix_in;
        end
    end

    // sum for the column one behind the arriving pixel
    always_comb begin
        p_far = win[m3_inc(cm3)];
        p_mid = win[m3_dec(cm3)];
        hout  = H_W'(p_far) * H_W'(W_SIDE)
              + H_W'(p_mid) * H_W'(W_CTR)
              + H_W'(pix_in) * H_W'(W_SIDE);
    end

endmodule

// File: rtl/gblur_vpass.sv
module gblur_vpass
    import gblur_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int IMG_W  = 16,
    parameter int W_CTR  = 2,
    parameter int W_SIDE = 1,
    localparam int T1D = W_CTR + 2 * W_SIDE,
    localparam int T2D = T1D * T1D,
    localparam int SH  = $clog2(T2D),
    localparam int H_W = sum_bits(PIX_W, T1D),
    localparam int V_W = sum_bits(PIX_W, T2D),
    localparam int CW  = $clog2(IMG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       rsel,
    input  logic [CW-1:0]    col,
    input  logic [H_W-1:0]   hin,
    input  logic             interior,
    output logic [PIX_W-1:0] vout
);

    localparam logic [V_W-1:0] PMAX = V_W'((1 << PIX_W) - 1);

    logic [H_W-1:0] lines [3][IMG_W];
    logic [H_W-1:0] h_up2, h_up1;
    logic [V_W-1:0] vp0, vp1, vp2, vnorm;

    // three-row store of horizontal sums, row index modulo 3
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < 3; r++)
                for (int c = 0; c < IMG_W; c++)
                    lines[r][c] <= '0;
        end else if (wr_en) begin
            lines[rsel][col] <= hin;
        end
    end

    // running partial sum over rows y-2, y-1 and the live row
    always_comb begin
        h_up2 = lines[m3_inc(rsel)][col];
        h_up1 = lines[m3_dec(rsel)][col];
        vp0   = V_W'(h_up2) * V_W'(W_SIDE);
        vp1   = vp0 + V_W'(h_up1) * V_W'(W_CTR);
        vp2   = vp1 + V_W'(hin) * V_W'(W_SIDE);
        vnorm = vp2 >> SH;
        vout  = interior ? PIX_W'(vnorm) : '0;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        interior |-> (vnorm <= PMAX)); // R10

endmodule

// File: rtl/gblur_stream.sv
module gblur_stream
    import gblur_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int IMG_W  = 16,
    parameter int IMG_H  = 12,
    parameter int W_CTR  = 2,
    parameter int W_SIDE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_sof,
    input  logic             in_eol,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_sof,
    output logic             out_eol
);

    localparam int T1D = W_CTR + 2 * W_SIDE;
    localparam int H_W = sum_bits(PIX_W, T1D);
    localparam int XW  = $clog2(IMG_W + 1);
    localparam int YW  = $clog2(IMG_H + 1);
    localparam int CW  = $clog2(IMG_W);
    localparam logic [XW-1:0] X_TWO  = XW'(2);
    localparam logic [XW-1:0] X_ONE  = XW'(1);
    localparam logic [XW-1:0] X_LAST = XW'(IMG_W - 1);
    localparam logic [XW-1:0] X_END  = XW'(IMG_W);
    localparam logic [YW-1:0] Y_TWO  = YW'(2);
    localparam logic [YW-1:0] Y_ONE  = YW'(1);
    localparam logic [YW-1:0] Y_LAST = YW'(IMG_H - 1);

    logic             out_space, step_go, step_take;
    logic [XW-1:0]    step_x;
    logic [YW-1:0]    step_y;
    logic [1:0]       step_cm3, step_rm3;
    logic [H_W-1:0]   hsum;
    logic [PIX_W-1:0] vpix;
    logic             interior, produce, hwrite;
    logic [CW-1:0]    col;

    gblur_scan_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eol   (in_eol),
        .out_space(out_space),
        .in_ready (in_ready),
        .step_go  (step_go),
        .step_take(step_take),
        .step_x   (step_x),
        .step_y   (step_y),
        .step_cm3 (step_cm3),
        .step_rm3 (step_rm3)
    );

    gblur_hpass #(.PIX_W(PIX_W), .W_CTR(W_CTR), .W_SIDE(W_SIDE)) u_hpass (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (step_take),
        .cm3   (step_cm3),
        .pix_in(in_pix),
        .hout  (hsum)
    );

    gblur_vpass #(.PIX_W(PIX_W), .IMG_W(IMG_W), .W_CTR(W_CTR), .W_SIDE(W_SIDE)) u_vpass (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hwrite),
        .rsel    (step_rm3),
        .col     (col),
        .hin     (hsum),
        .interior(interior),
        .vout    (vpix)
    );

    // the step at scan (x,y) emits output position (x-1,y-1)
    always_comb begin
        out_space = !out_valid || out_ready;
        col       = CW'(step_x - 1'b1);
        hwrite    = step_take && (step_x >= X_TWO);
        produce   = step_go && (step_x >= X_ONE) && (step_y >= Y_ONE);
        interior  = (step_x >= X_TWO) && (step_x <= X_LAST)
                 && (step_y >= Y_TWO) && (step_y <= Y_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
            out_sof   <= 1'b0;
            out_eol   <= 1'b0;
        end else if (step_go) begin
            out_valid <= produce;
            out_pix   <= vpix;
            out_sof   <= (step_x == X_ONE) && (step_y == Y_ONE);
            out_eol   <= (step_x == X_END);
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_sof))); // R7

endmodule

// File: tb/gblur_stream_test.sv
module gblur_stream_test;

    localparam int PW   = 8;
    localparam int TW   = 6;
    localparam int TH   = 5;
    localparam int NPIX = TW * TH;

    // pattern, seed, backpressure mode (0 none, 1 out stalls, 2 out stalls + input gaps)
    localparam int FRAMES [7][3] = '{
        '{0, 100, 0},
        '{1,   3, 0},
        '{2,   7, 1},
        '{3,   0, 2},
        '{4,   0, 1},
        '{2,  55, 2},
        '{1, 200, 0}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_ready, in_sof, in_eol;
    logic [PW-1:0] in_pix;
    logic          out_valid, out_ready, out_sof, out_eol;
    logic [PW-1:0] out_pix;

    int nchk  = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    gblur_stream #(.PIX_W(PW), .IMG_W(TW), .IMG_H(TH)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_pix   (in_pix),
        .in_sof   (in_sof),
        .in_eol   (in_eol),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_pix  (out_pix),
        .out_sof  (out_sof),
        .out_eol  (out_eol)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pixval(input int pat, input int seed, input int x, input int y);
        case (pat)
            0:       return seed & 255;
            1:       return (x * 37 + y * 11 + seed) & 255;
            2:       return ((x * 73) ^ (y * 151) ^ (seed * 29)) & 255;
            3:       return ((x + y) & 1) ? 255 : 0;
            default: return 255;
        endcase
    endfunction

    function automatic int wt(input int d);
        return (d == 0) ? 2 : 1;
    endfunction

    function automatic int expv(input int pat, input int seed, input int c, input int r);
        int s = 0;
        if (c == 0 || c == TW - 1 || r == 0 || r == TH - 1) return 0;
        for (int dy = -1; dy <= 1; dy++)
            for (int dx = -1; dx <= 1; dx++)
                s += wt(dx) * wt(dy) * pixval(pat, seed, c + dx, r + dy);
        return s / 16;
    endfunction

    // full frame with output checks
    task automatic run_frame(input int pat, input int seed, input int bp);
        int  pi = 0, oi = 0, cyc = 0, lat = -1, fstall = 0, hold_bad = 0;
        bit  started = 0, sof_taken = 0, hold_pend = 0;
        logic [PW-1:0] hold_pix = '0;
        while (oi < NPIX && cyc < 3000) begin
            @(negedge clk);
            out_ready = (bp == 0) ? 1'b1 : (cyc % 3 != 1);
            if (pi < NPIX && (bp < 2 || cyc % 2 == 0)) begin
                in_valid = 1'b1;
                in_pix   = PW'(pixval(pat, seed, pi % TW, pi / TW));
                in_sof   = (pi == 0);
                in_eol   = (pi % TW == TW - 1);
            end else begin
                in_valid = 1'b0;
                in_sof   = 1'b0;
                in_eol   = 1'b0;
            end
            #1;
            if (hold_pend && (!out_valid || out_pix != hold_pix)) hold_bad++;
            hold_pend = out_valid && !out_ready;
            hold_pix  = out_pix;
            if (out_valid && out_ready) begin
                if (out_sof) started = 1;
                if (started) begin
                    int c = oi % TW, r = oi / TW, e = expv(pat, seed, c, r);
                    string rq = (c == 0 || c == TW - 1 || r == 0 || r == TH - 1) ? "R4" :
                                (pat == 4) ? "R10" : "R3";
                    if (oi == 0) lat = pi;
                    check(int'(out_pix) == e, rq, int'(out_pix), e);
                    check(out_sof == (oi == 0), "R2 sof", int'(out_sof), int'(oi == 0));
                    check(out_eol == (c == TW - 1), "R2 eol", int'(out_eol), int'(c == TW - 1));
                    oi++;
                end
            end
            if (in_valid && !in_ready && sof_taken) fstall++;
            if (in_valid && in_ready) begin
                if (pi == 0) sof_taken = 1;
                pi++;
            end
            cyc++;
        end
        check(oi == NPIX, "R2 count (watchdog)", oi, NPIX);
        if (bp == 0) begin
            check(lat == TW + 2, "R5 latency", lat, TW + 2);
            check(fstall == TH - 1, "R6 flush stalls", fstall, TH - 1);
        end else begin
            check(hold_bad == 0, "R7 hold", hold_bad, 0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eol   = 1'b0;
    endtask

    // one pixel, waits for acceptance, counts outputs seen
    task automatic send_px(input int v, input bit sof, input bit eol, inout int seen);
        bit done = 0;
        int guard = 0;
        while (!done && guard < 100) begin
            @(negedge clk);
            out_ready = 1'b1;
            in_valid  = 1'b1;
            in_pix    = PW'(v);
            in_sof    = sof;
            in_eol    = eol;
            #1;
            if (out_valid) seen++;
            done = in_ready;
            guard++;
        end
        check(done, "R6 accept (watchdog)", int'(done), 1);
    endtask

    initial begin
        #(200000 * 10);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int seen, rdy_low, f0;
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_sof    = 1'b0;
        in_eol    = 1'b0;
        in_pix    = '0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

        for (int f = 0; f < 7; f++)
            run_frame(FRAMES[f][0], FRAMES[f][1], FRAMES[f][2]);

        // R8: restart in the middle of row 2
        seen = 0;
        for (int i = 0; i < 2 * TW + 3; i++)
            send_px(pixval(1, 9, i % TW, i / TW), i == 0, i % TW == TW - 1, seen);
        f0 = nfail;
        run_frame(2, 11, 1);
        check(nfail == f0, "R8 restart frame", nfail - f0, 0);

        // R9: end-of-line marker at column 1 of row 1
        seen = 0;
        for (int i = 0; i < TW + 2; i++)
            send_px(pixval(2, 9, i % TW, i / TW), i == 0, (i % TW == TW - 1) || (i == TW + 1), seen);
        rdy_low = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = 1'b0;
            in_eol   = 1'b0;
            in_pix   = PW'(77);
            #1;
            if (!in_ready) rdy_low++;
            if (out_valid) seen++;
        end
        check(seen == 0, "R9 no output after abort", seen, 0);
        check(rdy_low == 0, "R9 discard while idle", rdy_low, 0);
        @(negedge clk);
        in_valid = 1'b0;
        run_frame(3, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule